// File: doc/BRIEF.md
# Oversampled Slow-Clock Serializer

This block shifts a 48-bit word out one bit at a time. The pace is set by a slow external clock, roughly 1 MHz. All logic runs on a single fast system clock of about 24 MHz. The slow clock never drives the clock pin of any register. It enters as an ordinary data input and passes through a two-flop synchronizer. A third flop then delays the synchronized level so the logic can find its rising edge. The result is a strobe that is high for exactly one system-clock cycle per slow-clock period.

A one-cycle load pulse copies the parallel word into an internal shift register and raises the busy flag. Each strobe that follows moves the next bit, most significant first, onto the serial output. That bit holds until the next strobe. When the 48 bits have been sent, busy drops and the output returns low. A new word can then be loaded.

Top module: `strobe_serializer`

## Requirements
- R1: After reset, and whenever reset is asserted mid-word, `ser_out` is 0 and `busy` is 0.
- R2: A `load` pulse while `busy` is 0 captures `load_data` and sets `busy` to 1 on the next clock. `ser_out` stays 0 until the first rising edge of `ext_clk` after the load.
- R3: Each rising edge of `ext_clk` while busy causes exactly one output update. The update appears within 3 system-clock cycles after the first clock edge that samples the new high level. A falling edge of `ext_clk` causes no update.
- R4: Bits leave most significant first. The first update after a load presents `load_data[47]` and the k-th update presents `load_data[48-k]`.
- R5: Between updates `ser_out` holds its value.
- R6: `busy` stays 1 while the 48th bit is on the output. The 49th rising edge of `ext_clk` after a load clears `busy` and drives `ser_out` to 0.
- R7: A `load` pulse while `busy` is 1 is ignored: the word in progress continues unchanged.
- R8: While idle, edges on `ext_clk` leave `ser_out` at 0 and `busy` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Slow external clock, sampled as data |
| load | input | 1 | One-cycle request to capture a new word |
| load_data | input | 48 | Parallel word to send |
| ser_out | output | 1 | Serial data, most significant bit first |
| busy | output | 1 | High while a word is being sent |

## Verification
Several internal faults show up at the ports. A strobe that repeats or fires on the falling edge produces extra updates on `ser_out` within one slow-clock period. This shows as a toggle count that differs from the bit change expected. A wrong shift direction or a misloaded shift register corrupts the first bit sampled after a load. A counter off by one moves the fall of `busy` by one slow-clock period. That error is visible on the 48th or 49th edge. Every slow-clock edge starts at a random phase against the system clock, so the synchronizer latency takes on each of its possible values.

// File: rtl/strobe_serializer.sv
module strobe_serializer #(
  parameter int WORD_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  output logic              ser_out,
  output logic              busy
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              sync_a, sync_b, sync_d;
  logic              strobe;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              take;

  assign strobe = sync_b & ~sync_d;
  assign take   = load & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= 1'b0;
      sync_b <= 1'b0;
      sync_d <= 1'b0;
    end else begin
      sync_a <= ext_clk;
      sync_b <= sync_a;
      sync_d <= sync_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      ser_out <= 1'b0;
    end else if (take) begin
      shreg <= load_data;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (busy && strobe) begin
      if (cnt == CNT_W'(WORD_W)) begin
        busy    <= 1'b0;
        ser_out <= 1'b0;
      end else begin
        ser_out <= shreg[WORD_W-1];
        shreg   <= {shreg[WORD_W-2:0], 1'b0};
        cnt     <= cnt + 1'b1;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out); // R8
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !take) |=> $stable(ser_out)); // R5
  AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !strobe) |=> $stable(shreg)); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(WORD_W)); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && strobe && cnt == CNT_W'(WORD_W)) |=> !busy); // R6
endmodule

// File: tb/strobe_serializer_bench.sv
`timescale 1ns/1ps
module strobe_serializer_bench;
  localparam int W = 48;
  localparam int EXT_HALF = 96;
  localparam int NVEC = 4;
  localparam logic [W-1:0] VEC [NVEC] = '{
    48'hAAAA_AAAA_AAAA, 48'h1234_5678_9ABC,
    48'hFFFF_FFFF_FFFF, 48'h8000_0000_0001 };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk = 1'b0;
  logic load = 1'b0;
  logic [W-1:0] load_data = '0;
  logic ser_out, busy;

  int checks = 0, fails = 0, toggles = 0;
  logic last_out = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobe_serializer #(.WORD_W(W)) u_strobe_serializer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .load(load),
    .load_data(load_data), .ser_out(ser_out), .busy(busy));

  always @(negedge clk) begin
    if (ser_out !== last_out) toggles++;
    last_out = ser_out;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic align();
    int p;
    @(negedge clk);
    p = $urandom_range(0, 5);
    #((p < 3) ? p + 1 : p + 2);
  endtask

  task automatic pulse_load(input logic [W-1:0] d);
    @(negedge clk);
    load = 1'b1; load_data = d;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic ext_period(output logic s);
    time t;
    t = $time;
    ext_clk = 1'b1;
    repeat (4) @(negedge clk);
    s = ser_out;
    #(t + EXT_HALF - $time);
    ext_clk = 1'b0;
    #(EXT_HALF);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic s, prev, bitv;
    int t0;
    repeat (3) @(negedge clk);
    check(ser_out === 1'b0, "R1 reset ser_out", ser_out, 0);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    rst_n = 1'b1;

    t0 = toggles;
    for (int k = 0; k < 3; k++) begin
      align();
      ext_period(s);
      check(s === 1'b0 && busy === 1'b0, "R8 idle edge", {busy, s}, 0);
    end
    check(toggles == t0, "R8 idle toggles", toggles - t0, 0);

    for (int v = 0; v < NVEC; v++) begin
      pulse_load(VEC[v]);
      check(busy === 1'b1, "R2 busy after load", busy, 1);
      check(ser_out === 1'b0, "R2 output low before first edge", ser_out, 0);
      prev = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (v == 1 && i == 10) pulse_load(~VEC[v]);
        align();
        t0 = toggles;
        ext_period(s);
        bitv = VEC[v][W-1-i];
        check(s === bitv, "R4 bit order", s, bitv);
        check((toggles - t0) == int'(bitv != prev), "R3 R5 one update per period",
              toggles - t0, int'(bitv != prev));
        prev = bitv;
      end
      check(busy === 1'b1, "R6 busy through last bit", busy, 1);
      align();
      ext_period(s);
      check(busy === 1'b0, "R6 busy clears", busy, 0);
      check(ser_out === 1'b0, "R6 output low after word", ser_out, 0);
    end
    // R7 is covered by the extra load in vector 1 above; busy check here
    check(busy === 1'b0, "R7 ignored load left no second word", busy, 0);

    pulse_load(48'hF0F0_F0F0_F0F0);
    for (int k = 0; k < 5; k++) begin
      align();
      ext_period(s);
    end
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b0, "R1 mid-word reset busy", busy, 0);
    check(ser_out === 1'b0, "R1 mid-word reset ser_out", ser_out, 0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule